// File: doc/BRIEF.md
# Cartridge Bank-Switching Register Decoder

This block is the register side of a cartridge memory mapper that sits on the bus of an 8-bit processor. It watches processor writes in the upper half of the address space. From them it keeps the 8 KB program-ROM bank number for each of the four processor windows (0x8000, 0xA000, 0xC000, 0xE000), eight 1 KB character-ROM bank numbers, and a 2-bit nametable mirroring code. The 0xF000 page, ROM storage and the read data path lie outside this block.

Two switchable program registers feed the 0x8000 and 0xC000 windows. A control bit chooses which of the two a write in the 0x8000 page loads. When that bit changes, the two stored values trade places. The 0xA000 window has its own register, and the 0xE000 window is tied to the last bank. Each character register is written four bits at a time, at several aliased offsets within its page.

The block also turns the stored numbers into ROM addresses. It forms a registered program-ROM address from the processor address and a registered character-ROM address from the video address. The total program bank count is a parameter, and so is the number of character banks. Both counts are powers of two.

Top module: `cart_bank_decoder`

## Requirements
- R1: Synchronous reset sets the program windows to 0, 1, N-2 and N-1 (N = PRG_BANKS). It clears all character banks, sets the mirroring code to 0 and clears the swap-control bit.
- R2: A write anywhere in the 0xA000 page (address bits 15:12 = 0xA) sets the 0xA000 window to the data, from the next clock.
- R3: A write anywhere in the 0x8000 page loads the 0x8000 window when the swap-control bit is 0, and loads the 0xC000 window when it is 1. The other window keeps its value.
- R4: A write whose address masked with 0xF00F equals 0x9001 or 0x9004 stores data bit 1 as the swap-control bit. If that bit differs from the stored one, the 0x8000 and 0xC000 windows exchange values. If it is the same, both keep their values.
- R5: A write whose address masked with 0xF00F equals 0x9000 sets the mirroring code to data bits 1:0: 0 vertical, 1 horizontal, 2 single-screen low, 3 single-screen high.
- R6: Character register k (0..7) lives in page 0xB + k/2. Address bits 11:4 are ignored. For even k, offset 0x0 writes bits 3:0 and offset 0x2 or 0x8 writes bits 7:4. For odd k, offset 0x1 or 0x4 writes bits 3:0 and offset 0x3 or 0xC writes bits 7:4. The nibble written is always data bits 3:0.
- R7: A nibble write changes only its own four bits of the target register. The other nibble of that register is unchanged.
- R8: The 0xE000 window always reads N-1. Writes in the 0xF000 page, below 0x8000, or at offsets of pages 0x9 to 0xE not listed in R4 to R6 leave every bank output and the mirroring code unchanged.
- R9: One clock after the processor address is presented, prg_rom_addr equals {bank of window cpu_addr[14:13], cpu_addr[12:0]}, taken from the banks held before that clock edge.
- R10: One clock after the video address is presented, chr_rom_addr equals {character bank ppu_addr[12:10], ppu_addr[9:0]}, taken from the banks held before that clock edge.
- R11: Bank outputs keep only the low log2(count) bits of the written value: PRG_BW bits for program banks and CHR_BW bits for character banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Processor write strobe, one write per cycle while high |
| cpu_addr | input | 16 | Processor address, used for decoding and for the program lookup |
| cpu_data | input | 8 | Processor write data |
| ppu_addr | input | 13 | Video address bits 12:0 for the character lookup |
| prg_bank_flat | output | 4*PRG_BW | Window banks, the 0x8000 window in the lowest slice |
| chr_bank_flat | output | 8*CHR_BW | Character banks, register 0 in the lowest slice |
| mirror_mode | output | 2 | Nametable mirroring code |
| prg_rom_addr | output | PRG_BW+13 | Registered program-ROM address |
| chr_rom_addr | output | CHR_BW+10 | Registered character-ROM address |

## Verification
The hardest case to reach from the ports is a swap that actually moves data. The two switchable windows must hold different values, and the control bit must flip while writes then land in the other window. The stimulus first loads the 0x8000 window and flips the bit. It then writes the 0x8000 page again, so the value lands in the 0xC000 window, and rewrites the same bit to show that nothing moves. Finally it flips the bit back through an alias that has address bits 11:4 set. Character registers get every low and high alias offset. A random write sweep across all upper pages is then compared against the behavioural model on every clock.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  localparam logic [3:0] PG_SW_A   = 4'h8;
  localparam logic [3:0] PG_CTRL   = 4'h9;
  localparam logic [3:0] PG_FIX_A  = 4'hA;
  localparam logic [3:0] PG_CHR_LO = 4'hB;

  typedef struct packed {
    logic hit;
    logic odd;
    logic hi;
  } nib_sel_t;

  // Map a low address nibble to the character register slot and the nibble it writes
  function automatic nib_sel_t decode_nib(input logic [3:0] off);
    nib_sel_t s;
    case (off)
      4'h0:       s = '{hit: 1'b1, odd: 1'b0, hi: 1'b0};
      4'h2, 4'h8: s = '{hit: 1'b1, odd: 1'b0, hi: 1'b1};
      4'h1, 4'h4: s = '{hit: 1'b1, odd: 1'b1, hi: 1'b0};
      4'h3, 4'hC: s = '{hit: 1'b1, odd: 1'b1, hi: 1'b1};
      default:    s = '{hit: 1'b0, odd: 1'b0, hi: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cbd_ctrl_regs.sv
module cbd_ctrl_regs #(
  parameter int PRG_BANKS = 16,
  parameter int PRG_BW    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [3:0]            page,
  input  logic [3:0]            off,
  input  logic [7:0]            data,
  output logic [4*PRG_BW-1:0]   prg_bank_flat,
  output logic [1:0]            mirror_mode,
  output logic                  swap_mode
);
  import cbd_pkg::*;

  localparam logic [PRG_BW-1:0] BANK_LAST = PRG_BW'(PRG_BANKS - 1);
  localparam logic [PRG_BW-1:0] BANK_PEN  = PRG_BW'(PRG_BANKS - 2);
  localparam logic [PRG_BW-1:0] BANK_ONE  = PRG_BW'(1);

  logic [PRG_BW-1:0] win8_q, winc_q, wina_q;
  logic              swap_q;
  mirror_e           mir_q;

  logic sel_ctrl, sel_mode, sel_mir;
  assign sel_ctrl = we && (page == PG_CTRL);
  assign sel_mode = sel_ctrl && ((off == 4'h1) || (off == 4'h4));
  assign sel_mir  = sel_ctrl && (off == 4'h0);

  logic unused_data;
  assign unused_data = ^data;

  always_ff @(posedge clk) begin
    if (rst) begin
      win8_q <= '0;
      winc_q <= BANK_PEN;
      wina_q <= BANK_ONE;
      swap_q <= 1'b0;
      mir_q  <= MIR_VERT;
    end else begin
      if (we && page == PG_FIX_A)
        wina_q <= data[PRG_BW-1:0];
      if (we && page == PG_SW_A) begin
        if (swap_q) winc_q <= data[PRG_BW-1:0];
        else        win8_q <= data[PRG_BW-1:0];
      end
      if (sel_mode) begin
        swap_q <= data[1];
        if (data[1] != swap_q) begin
          win8_q <= winc_q;
          winc_q <= win8_q;
        end
      end
      if (sel_mir)
        mir_q <= mirror_e'(data[1:0]);
    end
  end

  assign prg_bank_flat = {BANK_LAST, winc_q, wina_q, win8_q};
  assign mirror_mode   = mir_q;
  assign swap_mode     = swap_q;

endmodule

// File: rtl/cbd_chr_regs.sv
module cbd_chr_regs #(
  parameter int CHR_BW = 7,
  parameter int N_REGS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [3:0]               page,
  input  logic [3:0]               off,
  input  logic [3:0]               nib,
  output logic [N_REGS*CHR_BW-1:0] chr_bank_flat
);
  import cbd_pkg::*;

  nib_sel_t sel;
  assign sel = decode_nib(off);

  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    localparam logic [3:0] MY_PAGE = PG_CHR_LO + 4'(k / 2);
    localparam logic       MY_ODD  = 1'(k % 2);

    logic [7:0] q;
    logic       hit;
    assign hit = we && (page == MY_PAGE) && sel.hit && (sel.odd == MY_ODD);

    always_ff @(posedge clk) begin
      if (rst)          q <= '0;
      else if (hit) begin
        if (sel.hi) q[7:4] <= nib;
        else        q[3:0] <= nib;
      end
    end

    logic unused_q;
    assign unused_q = ^q;
    assign chr_bank_flat[k*CHR_BW +: CHR_BW] = q[CHR_BW-1:0];
  end

endmodule

// File: rtl/cbd_addr_map.sv
module cbd_addr_map #(
  parameter int PRG_BW = 4,
  parameter int CHR_BW = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [14:0]           cpu_addr,
  input  logic [12:0]           ppu_addr,
  input  logic [4*PRG_BW-1:0]   prg_bank_flat,
  input  logic [8*CHR_BW-1:0]   chr_bank_flat,
  output logic [PRG_BW+12:0]    prg_rom_addr,
  output logic [CHR_BW+9:0]     chr_rom_addr
);
  logic [PRG_BW-1:0] prg_sel;
  logic [CHR_BW-1:0] chr_sel;

  assign prg_sel = prg_bank_flat[cpu_addr[14:13]*PRG_BW +: PRG_BW];
  assign chr_sel = chr_bank_flat[ppu_addr[12:10]*CHR_BW +: CHR_BW];

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_rom_addr <= '0;
      chr_rom_addr <= '0;
    end else begin
      prg_rom_addr <= {prg_sel, cpu_addr[12:0]};
      chr_rom_addr <= {chr_sel, ppu_addr[9:0]};
    end
  end

endmodule

// File: rtl/cart_bank_decoder.sv
module cart_bank_decoder #(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS = 128,
  localparam int PRG_BW   = $clog2(PRG_BANKS),
  localparam int CHR_BW   = $clog2(CHR_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cpu_we,
  input  logic [15:0]          cpu_addr,
  input  logic [7:0]           cpu_data,
  input  logic [12:0]          ppu_addr,
  output logic [4*PRG_BW-1:0]  prg_bank_flat,
  output logic [8*CHR_BW-1:0]  chr_bank_flat,
  output logic [1:0]           mirror_mode,
  output logic [PRG_BW+12:0]   prg_rom_addr,
  output logic [CHR_BW+9:0]    chr_rom_addr
);
  logic [3:0] page, off;
  logic       swap_mode;

  assign page = cpu_addr[15:12];
  assign off  = cpu_addr[3:0];

  cbd_ctrl_regs #(.PRG_BANKS(PRG_BANKS), .PRG_BW(PRG_BW)) u_ctrl (
    .clk(clk), .rst(rst), .we(cpu_we), .page(page), .off(off), .data(cpu_data),
    .prg_bank_flat(prg_bank_flat), .mirror_mode(mirror_mode), .swap_mode(swap_mode)
  );

  cbd_chr_regs #(.CHR_BW(CHR_BW), .N_REGS(8)) u_chr (
    .clk(clk), .rst(rst), .we(cpu_we), .page(page), .off(off), .nib(cpu_data[3:0]),
    .chr_bank_flat(chr_bank_flat)
  );

  cbd_addr_map #(.PRG_BW(PRG_BW), .CHR_BW(CHR_BW)) u_map (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr[14:0]), .ppu_addr(ppu_addr),
    .prg_bank_flat(prg_bank_flat), .chr_bank_flat(chr_bank_flat),
    .prg_rom_addr(prg_rom_addr), .chr_rom_addr(chr_rom_addr)
  );

endmodule

// File: rtl/cbd_checker.sv
module cbd_checker #(
  parameter int PRG_BANKS = 16,
  parameter int PRG_BW    = 4,
  parameter int CHR_BW    = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                cpu_we,
  input logic [15:0]         cpu_addr,
  input logic [7:0]          cpu_data,
  input logic [4*PRG_BW-1:0] prg_bank_flat,
  input logic [8*CHR_BW-1:0] chr_bank_flat,
  input logic [1:0]          mirror_mode,
  input logic [PRG_BW+12:0]  prg_rom_addr,
  input logic                swap_mode
);
  logic [PRG_BW-1:0] w0, w1, w2;
  assign w0 = prg_bank_flat[0*PRG_BW +: PRG_BW];
  assign w1 = prg_bank_flat[1*PRG_BW +: PRG_BW];
  assign w2 = prg_bank_flat[2*PRG_BW +: PRG_BW];

  logic [3:0] pg, of;
  assign pg = cpu_addr[15:12];
  assign of = cpu_addr[3:0];

  logic past_valid;
  always_ff @(posedge clk) past_valid <= !rst;

  logic unused_chk;
  assign unused_chk = ^{cpu_addr, cpu_data};

  // R2
  win_a_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && pg == 4'hA) |=> (w1 == $past(cpu_data[PRG_BW-1:0])));

  // R3
  sw_lo_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && pg == 4'h8 && !swap_mode) |=> (w0 == $past(cpu_data[PRG_BW-1:0]) && $stable(w2)));

  // R3
  sw_hi_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && pg == 4'h8 && swap_mode) |=> (w2 == $past(cpu_data[PRG_BW-1:0]) && $stable(w0)));

  // R4
  swap_move_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && pg == 4'h9 && (of == 4'h1 || of == 4'h4) && cpu_data[1] != swap_mode)
      |=> (w0 == $past(w2) && w2 == $past(w0)));

  // R5
  mirror_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && pg == 4'h9 && of == 4'h0) |=> (mirror_mode == $past(cpu_data[1:0])));

  // R8
  ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && (pg == 4'hF || !cpu_addr[15]))
      |=> ($stable(prg_bank_flat) && $stable(chr_bank_flat) && $stable(mirror_mode)));

  // R9
  prg_offset_chk: assert property (@(posedge clk) disable iff (rst)
    past_valid |-> (prg_rom_addr[12:0] == $past(cpu_addr[12:0])));

  // R8
  last_window_chk: assert property (@(posedge clk) disable iff (rst)
    (past_valid && $past(cpu_addr[14:13]) == 2'b11)
      |-> (prg_rom_addr[PRG_BW+12:13] == PRG_BW'(PRG_BANKS - 1)));

endmodule

bind cart_bank_decoder cbd_checker #(.PRG_BANKS(PRG_BANKS), .PRG_BW(PRG_BW), .CHR_BW(CHR_BW)) u_cbd_chk (
  .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
  .prg_bank_flat(prg_bank_flat), .chr_bank_flat(chr_bank_flat), .mirror_mode(mirror_mode),
  .prg_rom_addr(prg_rom_addr), .swap_mode(swap_mode)
);

// File: tb/cart_bank_decoder_bench.sv
module cart_bank_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 16;
  localparam int NC  = 128;
  localparam int PBW = 4;
  localparam int CBW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_we = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic [12:0] ppu_addr = 13'h0000;
  logic [4*PBW-1:0] prg_bank_flat;
  logic [8*CBW-1:0] chr_bank_flat;
  logic [1:0]       mirror_mode;
  logic [PBW+12:0]  prg_rom_addr;
  logic [CBW+9:0]   chr_rom_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_decoder #(.PRG_BANKS(NB), .CHR_BANKS(NC)) u_cart_bank_decoder (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .ppu_addr(ppu_addr), .prg_bank_flat(prg_bank_flat), .chr_bank_flat(chr_bank_flat),
    .mirror_mode(mirror_mode), .prg_rom_addr(prg_rom_addr), .chr_rom_addr(chr_rom_addr)
  );

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_lo, m_hi, m_a, m_mode, m_mir, m_pa, m_ca;
  int m_chr[8];
  bit m_valid = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_lo = 0; m_hi = NB - 2; m_a = 1; m_mode = 0; m_mir = 0; m_pa = 0; m_ca = 0;
      foreach (m_chr[i]) m_chr[i] = 0;
      m_valid = 1;
    end else begin
      int w, bank, pg, of, ri;
      w = cpu_addr[14:13];
      bank = (w == 0) ? m_lo : (w == 1) ? m_a : (w == 2) ? m_hi : NB - 1;
      m_pa = ((bank % NB) << 13) | (cpu_addr & 16'h1FFF);
      m_ca = ((m_chr[ppu_addr[12:10]] % NC) << 10) | (ppu_addr & 13'h3FF);
      if (cpu_we) begin
        pg = cpu_addr >> 12;
        of = cpu_addr & 15;
        if (pg == 8) begin
          if (m_mode == 1) m_hi = cpu_data % NB; else m_lo = cpu_data % NB;
        end else if (pg == 10) m_a = cpu_data % NB;
        else if (pg == 9) begin
          if (of == 0) m_mir = cpu_data & 3;
          if (of == 1 || of == 4) begin
            if (((cpu_data >> 1) & 1) != m_mode) begin
              int t; t = m_lo; m_lo = m_hi; m_hi = t;
            end
            m_mode = (cpu_data >> 1) & 1;
          end
        end
        if (pg >= 11 && pg <= 14) begin
          ri = (pg - 11) * 2;
          if (of == 0)                m_chr[ri]   = (m_chr[ri] & 8'hF0) | (cpu_data & 15);
          else if (of == 2 || of == 8)  m_chr[ri]   = (m_chr[ri] & 8'h0F) | ((cpu_data & 15) << 4);
          else if (of == 1 || of == 4)  m_chr[ri+1] = (m_chr[ri+1] & 8'hF0) | (cpu_data & 15);
          else if (of == 3 || of == 12) m_chr[ri+1] = (m_chr[ri+1] & 8'h0F) | ((cpu_data & 15) << 4);
        end
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (m_valid && !finished) begin
      logic [4*PBW-1:0] ep;
      logic [8*CBW-1:0] ec;
      ep = {PBW'(NB - 1), PBW'(m_hi), PBW'(m_a), PBW'(m_lo)};
      for (int i = 0; i < 8; i++) ec[i*CBW +: CBW] = CBW'(m_chr[i]);
      chk(cur_req, int'(prg_bank_flat), int'(ep));
      chk(cur_req, int'(chr_bank_flat[31:0]), int'(ec[31:0]));
      chk(cur_req, int'(chr_bank_flat[8*CBW-1:32]), int'(ec[8*CBW-1:32]));
      chk(cur_req, int'(mirror_mode), m_mir);
      chk("R9", int'(prg_rom_addr), m_pa);
      chk("R10", int'(chr_rom_addr), m_ca);
    end
  end

  function automatic int win(input int i);
    return int'(prg_bank_flat[i*PBW +: PBW]);
  endfunction
  function automatic int chrb(input int i);
    return int'(chr_bank_flat[i*CBW +: CBW]);
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_we = 1'b1; cpu_addr = a; cpu_data = d;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic look(input logic [15:0] a, input logic [12:0] p);
    @(negedge clk); cpu_addr = a; ppu_addr = p;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_chr[8];
    logic [4*PBW-1:0] snap_p;
    logic [8*CBW-1:0] snap_c;
    logic [1:0] snap_m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    chk("R1", win(0), 0); chk("R1", win(1), 1);
    chk("R1", win(2), NB - 2); chk("R1", win(3), NB - 1);
    chk("R1", int'(mirror_mode), 0); chk("R1", int'(chr_bank_flat[31:0]), 0);

    // R2 fixed-A window, any offset in page; R11 masking
    cur_req = "R2";
    wr(16'hA000, 8'h05); chk("R2", win(1), 5);
    wr(16'hAFFF, 8'h3A); chk("R11", win(1), 4'hA);

    // R3 / R4 switchable windows and swap
    cur_req = "R3";
    wr(16'h8000, 8'h03); chk("R3", win(0), 3); chk("R3", win(2), 14);
    cur_req = "R4";
    wr(16'h9001, 8'h02); chk("R4", win(0), 14); chk("R4", win(2), 3);
    cur_req = "R3";
    wr(16'h8ABC, 8'h09); chk("R3", win(2), 9); chk("R3", win(0), 14);
    cur_req = "R4";
    wr(16'h9004, 8'h02); chk("R4", win(0), 14); chk("R4", win(2), 9);
    wr(16'h9FF4, 8'h00); chk("R4", win(0), 9); chk("R4", win(2), 14);

    // R5 mirroring codes
    cur_req = "R5";
    for (int i = 0; i < 4; i++) begin
      wr(16'h9000, 8'hFC | 8'(i)); chk("R5", int'(mirror_mode), i);
    end

    // R6 / R7 character nibble writes through every alias
    cur_req = "R6";
    for (int k = 0; k < 8; k++) begin
      logic [15:0] base;
      int lo, hi;
      base = {4'(11 + k / 2), 12'h000};
      lo = (k + 1) & 15;
      hi = (k + 9) & 15;
      wr(base | ((k % 2) ? 16'h0001 : 16'h0000), 8'hF0 | 8'(lo));
      wr(base | ((k % 2) ? 16'h0003 : 16'h0002), 8'(hi));
      chk("R6", chrb(k), ((hi << 4) | lo) % NC);
      wr(base | ((k % 2) ? 16'h000C : 16'h0008), 8'h05);
      chk("R7", chrb(k), ((5 << 4) | lo) % NC);
      wr(base | ((k % 2) ? 16'h0774 : 16'h0770), 8'h0E);
      chk("R7", chrb(k), ((5 << 4) | 14) % NC);
      exp_chr[k] = ((5 << 4) | 14) % NC;
    end

    // R8 ignored writes
    cur_req = "R8";
    snap_p = prg_bank_flat; snap_c = chr_bank_flat; snap_m = mirror_mode;
    wr(16'hF000, 8'h77); wr(16'hF001, 8'h03); wr(16'h7000, 8'h33);
    wr(16'h0A00, 8'h11); wr(16'hB005, 8'h0F); wr(16'h9002, 8'h02);
    wr(16'hE00F, 8'h0F); wr(16'hC006, 8'h0F);
    chk("R8", int'(prg_bank_flat), int'(snap_p));
    chk("R8", int'(chr_bank_flat[31:0]), int'(snap_c[31:0]));
    chk("R8", int'(chr_bank_flat[8*CBW-1:32]), int'(snap_c[8*CBW-1:32]));
    chk("R8", int'(mirror_mode), int'(snap_m));
    chk("R8", win(3), NB - 1);

    // R9 / R10 address formation
    cur_req = "R9";
    look(16'hC123, 13'h0C55);
    chk("R9", int'(prg_rom_addr), (14 << 13) | 16'h0123);
    chk("R10", int'(chr_rom_addr), (exp_chr[3] << 10) | 16'h0055);
    look(16'hE456, 13'h1FFF);
    chk("R9", int'(prg_rom_addr), (15 << 13) | 16'h0456);
    chk("R10", int'(chr_rom_addr), (exp_chr[7] << 10) | 16'h03FF);
    look(16'h8001, 13'h0000);
    chk("R9", int'(prg_rom_addr), (9 << 13) | 1);

    // Random sweep over the upper pages, compared by the model every clock
    cur_req = "R6";
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      a = {1'b1, 15'($urandom)};
      if (($urandom & 3) == 0) a[11:4] = 8'h00;
      @(negedge clk);
      cpu_we = ($urandom & 1) == 1;
      cpu_addr = a;
      cpu_data = 8'($urandom);
      ppu_addr = 13'($urandom);
    end
    @(negedge clk); cpu_we = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule